// File: doc/BRIEF.md
# Redundant Memory Access Filter

This block sits between a requester and a synchronous RAM that returns read data one cycle after its read enable. It passes the address and write data straight through to the memory. It holds back the memory enables for accesses whose outcome is already known. There are three such cases:

- A read whose result the requester has flagged as unobserved.
- A read that repeats the last enabled read address with no write request since.
- A write whose address and data both match the last write that reached the memory.

For a suppressed repeat read, the block returns the data it captured from the last real read. It does so with the same one-cycle latency as a real read, so the requester cannot tell the two apart.

The filter keeps a small read cache and a small write cache. The read cache is the last enabled read address plus a valid bit. The write cache is the last enabled write address and data plus a valid bit. It also keeps a registered copy of the last read data. Two counters report how many reads and how many writes were held back, so the saving can be checked.

Top module: `ram_gate_filter`

## Requirements
- R1: A read request (`req_rd`=1, `req_wr`=0) with `req_obs`=0 never asserts `mem_rd_en`.
- R2: An observed read to the address of the last enabled read is held back (`mem_rd_en`=0) if no write request has arrived since. One cycle later `rsp_rdata` shows the data of that earlier read.
- R3: A write request whose address and data equal those of the last enabled write is held back (`mem_wr_en`=0). Any other write request asserts `mem_wr_en`.
- R4: Every write request, including a held-back one, clears the read cache. The next observed read therefore enables the memory.
- R5: When `req_rd` and `req_wr` are both high, only the write is handled. `mem_rd_en` stays 0, and the read is not counted as suppressed.
- R6: In the cycle after `mem_rd_en`, `rsp_rdata` equals `mem_rdata`. In later cycles with no enabled read, `rsp_rdata` holds that value. `mem_addr` and `mem_wdata` always equal `req_addr` and `req_wdata`.
- R7: A read held back only because it is unobserved does not change the read cache or the held data.
- R8: `rd_drop_cnt` counts read requests (without `req_wr`) that did not enable the memory. `wr_drop_cnt` counts held-back write requests. Both wrap modulo 2^CW.
- R9: Reset clears both valid bits, both counters and `rsp_rdata`. The first read and the first write after reset always enable the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_obs | input | 1 | Requester will use this read's result |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| rsp_rdata | output | DW | Read result, one cycle after the request |
| mem_rd_en | output | 1 | Gated memory read enable |
| mem_wr_en | output | 1 | Gated memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_rd_en` |
| rd_drop_cnt | output | CW | Suppressed read count |
| wr_drop_cnt | output | CW | Suppressed write count |

## Verification
The assertions check the per-cycle rules on every cycle:
- No unobserved read is enabled, and a write blocks a same-cycle read.
- Back-to-back identical reads and writes are held back.
- A read right after a write request always reaches the memory.
- The response follows `mem_rdata` after a real read and stays stable otherwise.
- Each counter moves by exactly one per dropped access.

Only the bench scenarios show the longer-range behaviour:
- Returned data stays correct across interleaved unobserved reads to other addresses.
- The read cache is cleared by a write that was itself held back.
- Caches and counters are cleared by a mid-run reset.

// File: rtl/ram_gate_filter.sv
module ram_gate_filter #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic          req_obs,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [CW-1:0] rd_drop_cnt,
  output logic [CW-1:0] wr_drop_cnt
);

  logic          rd_vld_q, wr_vld_q, rd_pend_q;
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  logic [DW-1:0] wr_data_q, hold_q;

  logic rd_req, rd_same, wr_same;

  assign rd_req  = req_rd && !req_wr;
  assign rd_same = rd_vld_q && (req_addr == rd_addr_q);
  assign wr_same = wr_vld_q && (req_addr == wr_addr_q) && (req_wdata == wr_data_q);

  assign mem_rd_en = rd_req && req_obs && !rd_same;
  assign mem_wr_en = req_wr && !wr_same;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign rsp_rdata = rd_pend_q ? mem_rdata : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q    <= 1'b0;
      rd_addr_q   <= '0;
      rd_pend_q   <= 1'b0;
      hold_q      <= '0;
      rd_drop_cnt <= '0;
    end else begin
      rd_pend_q <= mem_rd_en;
      if (rd_pend_q) hold_q <= mem_rdata;
      if (req_wr) begin
        rd_vld_q <= 1'b0;
      end else if (mem_rd_en) begin
        rd_vld_q  <= 1'b1;
        rd_addr_q <= req_addr;
      end
      if (rd_req && !mem_rd_en) rd_drop_cnt <= rd_drop_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_vld_q    <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      wr_drop_cnt <= '0;
    end else begin
      if (mem_wr_en) begin
        wr_vld_q  <= 1'b1;
        wr_addr_q <= req_addr;
        wr_data_q <= req_wdata;
      end
      if (req_wr && !mem_wr_en) wr_drop_cnt <= wr_drop_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ram_gate_filter_sva.sv
module ram_gate_filter_sva #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_rd,
  input logic          req_wr,
  input logic          req_obs,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [DW-1:0] rsp_rdata,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [DW-1:0] mem_rdata,
  input logic [CW-1:0] rd_drop_cnt,
  input logic [CW-1:0] wr_drop_cnt
);

  logic up_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;

  a_r1_unobserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_obs) |-> !mem_rd_en);

  a_r2_repeat_read: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(mem_rd_en) && req_rd && !req_wr && req_addr == $past(req_addr)) |-> !mem_rd_en);

  a_r3_repeat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(mem_wr_en) && req_wr && req_addr == $past(req_addr)
     && req_wdata == $past(req_wdata)) |-> !mem_wr_en);

  a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(req_wr) && req_rd && !req_wr && req_obs) |-> mem_rd_en);

  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |-> !mem_rd_en);

  a_r6_fresh_data: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(mem_rd_en)) |-> rsp_rdata == mem_rdata);

  a_r6_held_data: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(mem_rd_en)) |-> $stable(rsp_rdata));

  a_r8_rd_count: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(req_rd && !req_wr && !mem_rd_en)) |-> rd_drop_cnt == $past(rd_drop_cnt) + 1'b1);

  a_r8_wr_count: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(req_wr && !mem_wr_en)) |-> $stable(wr_drop_cnt));

endmodule

bind ram_gate_filter ram_gate_filter_sva #(.AW(AW), .DW(DW), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_obs(req_obs),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_rdata(mem_rdata),
  .rd_drop_cnt(rd_drop_cnt), .wr_drop_cnt(wr_drop_cnt)
);

// File: tb/ram_gate_filter_test.sv
`timescale 1ns/1ps
module ram_gate_filter_test;
  localparam int AW = 4, DW = 8, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_rd = 0, req_wr = 0, req_obs = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_rd_en, mem_wr_en;
  logic [CW-1:0] rd_drop_cnt, wr_drop_cnt;

  always #10 clk = ~clk;

  ram_gate_filter #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_obs(req_obs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rd_drop_cnt(rd_drop_cnt), .wr_drop_cnt(wr_drop_cnt));

  logic [DW-1:0] ram [1<<AW];
  logic [DW-1:0] ram_q = '0;
  initial for (int i = 0; i < (1<<AW); i++) ram[i] = '0;
  always @(posedge clk) begin
    if (mem_wr_en) ram[mem_addr] <= mem_wdata;
    if (mem_rd_en) ram_q <= ram[mem_addr];
  end
  assign mem_rdata = ram_q;

  int total = 0, bad = 0;
  logic [DW-1:0] shadow [1<<AW];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {rd, wr, obs, addr[3:0], wdata[7:0], exp_rd_en, exp_wr_en}
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,4'd3,8'h11,1'b0,1'b1},
    {1'b0,1'b1,1'b0,4'd3,8'h11,1'b0,1'b0},
    {1'b0,1'b1,1'b0,4'd3,8'h12,1'b0,1'b1},
    {1'b1,1'b0,1'b1,4'd3,8'h00,1'b1,1'b0},
    {1'b1,1'b0,1'b1,4'd3,8'h00,1'b0,1'b0},
    {1'b1,1'b0,1'b0,4'd3,8'h00,1'b0,1'b0},
    {1'b1,1'b0,1'b0,4'd5,8'h00,1'b0,1'b0},
    {1'b1,1'b0,1'b1,4'd3,8'h00,1'b0,1'b0},
    {1'b0,1'b1,1'b0,4'd3,8'h12,1'b0,1'b0},
    {1'b1,1'b0,1'b1,4'd3,8'h00,1'b1,1'b0},
    {1'b0,1'b1,1'b0,4'd7,8'h44,1'b0,1'b1},
    {1'b1,1'b0,1'b1,4'd7,8'h00,1'b1,1'b0},
    {1'b1,1'b0,1'b1,4'd9,8'h00,1'b1,1'b0},
    {1'b1,1'b0,1'b1,4'd7,8'h00,1'b1,1'b0},
    {1'b1,1'b1,1'b1,4'd9,8'h55,1'b0,1'b1},
    {1'b0,1'b1,1'b0,4'd9,8'h55,1'b0,1'b0},
    {1'b0,1'b1,1'b0,4'd3,8'h12,1'b0,1'b1},
    {1'b0,1'b0,1'b0,4'd0,8'h00,1'b0,1'b0}
  };

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic pend;
    logic [DW-1:0] pend_data;
    for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
    pend = 0; pend_data = '0;
    repeat (3) @(negedge clk);
    check("R9 reset rsp_rdata", rsp_rdata, 0);
    check("R9 reset rd_drop_cnt", rd_drop_cnt, 0);
    check("R9 reset wr_drop_cnt", wr_drop_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (pend) check($sformatf("R2/R6 row %0d rsp_rdata", v - 1), rsp_rdata, pend_data);
      {req_rd, req_wr, req_obs, req_addr, req_wdata} = VEC[v][16:2];
      #1;
      check($sformatf("R1-5 row %0d mem_rd_en", v), mem_rd_en, VEC[v][1]);
      check($sformatf("R3 row %0d mem_wr_en", v), mem_wr_en, VEC[v][0]);
      check($sformatf("R6 row %0d mem_addr", v), mem_addr, req_addr);
      pend = req_rd && !req_wr && req_obs;
      pend_data = shadow[req_addr];
      if (req_wr) shadow[req_addr] = req_wdata;
      @(negedge clk);
    end

    // R8: reads dropped on rows 4,5,6,7; writes dropped on rows 1,8,15
    check("R8 rd_drop_cnt", rd_drop_cnt, 4);
    check("R8 wr_drop_cnt", wr_drop_cnt, 3);

    // R6: response holds while idle
    repeat (2) @(negedge clk);
    check("R6 hold after idle", rsp_rdata, 8'h44);

    // R7: unobserved read elsewhere, then repeat of last read keeps old data
    req_rd = 1; req_obs = 1; req_addr = 4'd9; #1;
    check("R7 setup read enabled", mem_rd_en, 1);
    @(negedge clk);
    req_obs = 0; req_addr = 4'd3; #1;
    check("R1 unobserved read quiet", mem_rd_en, 0);
    @(negedge clk);
    req_obs = 1; req_addr = 4'd9; #1;
    check("R7 repeat still suppressed", mem_rd_en, 0);
    @(negedge clk);
    req_rd = 0; req_obs = 0;
    check("R7 held data unchanged", rsp_rdata, 8'h55);

    // R9: reset mid-run clears caches and counters
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R9 rd_drop_cnt cleared", rd_drop_cnt, 0);
    check("R9 rsp_rdata cleared", rsp_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    req_wr = 1; req_addr = 4'd3; req_wdata = 8'h12; #1;
    check("R9 first write enabled", mem_wr_en, 1);
    @(negedge clk);
    req_wr = 0; req_rd = 1; req_obs = 1; req_addr = 4'd7; #1;
    check("R9 first read enabled", mem_rd_en, 1);
    @(negedge clk);
    req_rd = 0; req_obs = 0;
    check("R6 read data after reset", rsp_rdata, 8'h44);
    check("R9 wr_drop_cnt after reset", wr_drop_cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule